// File: doc/BRIEF.md
# Quadrant-Folded One-Bit Phase Error Lookup

This block turns one complex sample into a single phase error bit. Each 6-bit I and 6-bit Q pair in two's complement addresses a table of 4096 one-bit entries. The table is stored as 256 words of sixteen bits. Software fills it through a small register-write port, and the table cannot be read back through that port. The looked-up bit goes out on two outputs that always agree. One feeds the loop filter and the other is the external error pin.

When the constellation has the same shape in all four quadrants, software can set a mode bit that turns on quadrant folding. The block then replaces I and Q by their magnitudes, so only one quadrant of the table is used. It inverts the looked-up bit whenever exactly one of the two components is negative, which restores the correct sign for the original quadrant. A constellation without that symmetry must be run with folding off.

A sample is accepted with a valid strobe. The error bit and its own valid flag come out one clock later.

Top module: `qpe_phase_lut`

## Requirements
- R1: While reset is active, and after it is released, err_vld, err_loop and err_pin are 0. The fold mode is off, and a read at control address 0 returns 0.
- R2: With fold mode off, the lookup address is {I[5:0], Q[5:0]}. Address bits [11:4] select the table word and bits [3:0] select the bit within that word, where bit 0 is the LSB. The output equals that bit.
- R3: err_vld is 1 in exactly the cycle after a cycle with smp_vld high. In cycles after smp_vld was low, err_vld is 0 and err_loop and err_pin keep their previous values.
- R4: A control write to an address A in the range 256 to 511 stores cfg_wdata as table word A-256. A sample presented in any cycle after the write cycle sees the new word.
- R5: cfg_rdata is 0 for every control address from 256 to 511, whatever the table holds.
- R6: A control write to address 0 sets the fold mode to cfg_wdata[0]. A read at address 0 returns the mode in bit 0 and zeros in bits 15:1. Writes to addresses 1 to 255 change neither the mode nor the table.
- R7: With fold mode on, the lookup address is {1'b0, |I|[4:0], 1'b0, |Q|[4:0]}. The magnitude of -32 saturates to 31.
- R8: With fold mode on, the output is the looked-up bit XOR (I[5] XOR Q[5]).
- R9: err_pin equals err_loop in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| cfg_wr | input | 1 | Control write strobe |
| cfg_addr | input | 9 | Control address: 0 is the mode register, 256 to 511 are the table words |
| cfg_wdata | input | 16 | Control write data |
| cfg_rdata | output | 16 | Control read data for cfg_addr (combinational) |
| smp_vld | input | 1 | Sample valid |
| smp_i | input | 6 | In-phase sample, two's complement |
| smp_q | input | 6 | Quadrature sample, two's complement |
| err_vld | output | 1 | Error valid, one cycle after smp_vld |
| err_loop | output | 1 | Phase error bit toward the loop filter |
| err_pin | output | 1 | Same phase error bit for the external pin |

## Verification
The assertions check on every cycle that the valid flag follows the strobe one cycle later and that the error holds while no sample arrives. They also check that the two error outputs match, that table addresses read as zero, that a mode write takes effect in the next cycle, and that folding clears both sign positions of the lookup address. Whether the right table bit is chosen, whether saturation of -32 and the polarity flip are right, and whether a freshly written word is seen by the very next sample can only be shown by the bench. It does this by comparing outputs with its own model of the table under directed corner samples and random traffic.

// File: rtl/qpe_pkg.sv
package qpe_pkg;

  typedef enum logic [1:0] {
    CFG_NONE  = 2'd0,
    CFG_MODE  = 2'd1,
    CFG_TABLE = 2'd2
  } cfg_sel_e;

endpackage

// File: rtl/qpe_rst_sync.sv
module qpe_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/qpe_cfg_decode.sv
module qpe_cfg_decode
  import qpe_pkg::*;
#(
  parameter int CFG_AW     = 9,
  parameter int DATA_W     = 16,
  parameter int WORDS      = 256,
  parameter int TABLE_BASE = 256,
  parameter int MODE_ADDR  = 0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_wr,
  input  logic [CFG_AW-1:0]         cfg_addr,
  input  logic [DATA_W-1:0]         cfg_wdata,
  output logic [DATA_W-1:0]         cfg_rdata,
  output logic                      qmap_en,
  output logic                      tbl_we,
  output logic [$clog2(WORDS)-1:0]  tbl_widx,
  output logic [DATA_W-1:0]         tbl_wdata
);

  localparam int WIDX_W = $clog2(WORDS);
  localparam logic [CFG_AW-1:0] TBL_LO  = CFG_AW'(TABLE_BASE);
  localparam logic [CFG_AW-1:0] TBL_HI  = CFG_AW'(TABLE_BASE + WORDS - 1);
  localparam logic [CFG_AW-1:0] MODE_AD = CFG_AW'(MODE_ADDR);

  cfg_sel_e sel;
  logic     mode_q;
  logic     mode_d;

  // address decode
  always_comb begin
    if (cfg_addr == MODE_AD) begin
      sel = CFG_MODE;
    end else if ((cfg_addr >= TBL_LO) && (cfg_addr <= TBL_HI)) begin
      sel = CFG_TABLE;
    end else begin
      sel = CFG_NONE;
    end
  end

  // mode register: next state
  always_comb begin
    mode_d = mode_q;
    if (cfg_wr && (sel == CFG_MODE)) begin
      mode_d = cfg_wdata[0];
    end
  end

  // mode register: state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
    end
  end

  // table write path
  always_comb begin
    tbl_we    = cfg_wr && (sel == CFG_TABLE);
    tbl_widx  = WIDX_W'(cfg_addr - TBL_LO);
    tbl_wdata = cfg_wdata;
  end

  // read path: the table never appears here
  always_comb begin
    if (sel == CFG_MODE) begin
      cfg_rdata = DATA_W'(mode_q);
    end else begin
      cfg_rdata = '0;
    end
  end

  assign qmap_en = mode_q;

endmodule

// File: rtl/qpe_fold.sv
module qpe_fold #(
  parameter int SW = 6
) (
  input  logic [SW-1:0]   smp_i,
  input  logic [SW-1:0]   smp_q,
  input  logic            qmap_en,
  output logic [2*SW-1:0] lut_addr,
  output logic            flip
);

  // component 1 is I (upper field), component 0 is Q (lower field)
  for (genvar k = 0; k < 2; k++) begin : g_comp
    logic [SW-1:0] comp;
    logic [SW-1:0] mag_full;
    logic [SW-2:0] mag;
    logic [SW-1:0] field;

    assign comp = (k == 1) ? smp_i : smp_q;

    always_comb begin
      mag_full = comp[SW-1] ? (~comp + 1'b1) : comp;
      // only the most negative code keeps its MSB after negation
      mag      = mag_full[SW-1] ? '1 : mag_full[SW-2:0];
      field    = qmap_en ? {1'b0, mag} : comp;
    end

    assign lut_addr[k*SW +: SW] = field;
  end

  assign flip = qmap_en & (smp_i[SW-1] ^ smp_q[SW-1]);

endmodule

// File: rtl/qpe_table.sv
module qpe_table #(
  parameter int WORD_W = 16,
  parameter int WORDS  = 256
) (
  input  logic                                     clk,
  input  logic                                     we,
  input  logic [$clog2(WORDS)-1:0]                 widx,
  input  logic [WORD_W-1:0]                        wdata,
  input  logic [$clog2(WORDS)+$clog2(WORD_W)-1:0]  raddr,
  output logic                                     rbit
);

  localparam int BSEL_W = $clog2(WORD_W);

  logic [WORD_W-1:0] mem [WORDS];
  logic [WORD_W-1:0] rword;

  always_ff @(posedge clk) begin
    if (we) begin
      mem[widx] <= wdata;
    end
  end

  always_comb begin
    rword = mem[raddr[BSEL_W +: $clog2(WORDS)]];
    rbit  = rword[raddr[BSEL_W-1:0]];
  end

endmodule

// File: rtl/qpe_phase_lut.sv
module qpe_phase_lut #(
  parameter int SW         = 6,
  parameter int WORD_W     = 16,
  parameter int CFG_AW     = 9,
  parameter int TABLE_BASE = 256,
  parameter int MODE_ADDR  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic              smp_vld,
  input  logic [SW-1:0]     smp_i,
  input  logic [SW-1:0]     smp_q,
  output logic              err_vld,
  output logic              err_loop,
  output logic              err_pin
);

  localparam int ADDR_W = 2 * SW;
  localparam int BSEL_W = $clog2(WORD_W);
  localparam int WIDX_W = ADDR_W - BSEL_W;
  localparam int WORDS  = 1 << WIDX_W;

  logic              rst_sync_n;
  logic              qmap_en;
  logic              tbl_we;
  logic [WIDX_W-1:0] tbl_widx;
  logic [WORD_W-1:0] tbl_wdata;
  logic [ADDR_W-1:0] fold_addr;
  logic              flip;
  logic              raw_bit;

  logic vld_q, vld_d;
  logic err_q, err_d;

  qpe_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  qpe_cfg_decode #(
    .CFG_AW     (CFG_AW),
    .DATA_W     (WORD_W),
    .WORDS      (WORDS),
    .TABLE_BASE (TABLE_BASE),
    .MODE_ADDR  (MODE_ADDR)
  ) i_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .qmap_en   (qmap_en),
    .tbl_we    (tbl_we),
    .tbl_widx  (tbl_widx),
    .tbl_wdata (tbl_wdata)
  );

  qpe_fold #(.SW(SW)) i_fold (
    .smp_i    (smp_i),
    .smp_q    (smp_q),
    .qmap_en  (qmap_en),
    .lut_addr (fold_addr),
    .flip     (flip)
  );

  qpe_table #(.WORD_W(WORD_W), .WORDS(WORDS)) i_table (
    .clk   (clk),
    .we    (tbl_we),
    .widx  (tbl_widx),
    .wdata (tbl_wdata),
    .raddr (fold_addr),
    .rbit  (raw_bit)
  );

  // output stage: next state
  always_comb begin
    vld_d = smp_vld;
    err_d = err_q;
    if (smp_vld) begin
      err_d = raw_bit ^ flip;
    end
  end

  // output stage: state
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      err_q <= err_d;
    end
  end

  assign err_vld  = vld_q;
  assign err_loop = err_q;
  assign err_pin  = err_q;

endmodule

// File: rtl/qpe_phase_lut_chk.sv
module qpe_phase_lut_chk #(
  parameter int SW     = 6,
  parameter int WORD_W = 16,
  parameter int CFG_AW = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [WORD_W-1:0] cfg_wdata,
  input logic [WORD_W-1:0] cfg_rdata,
  input logic              smp_vld,
  input logic              err_vld,
  input logic              err_loop,
  input logic              err_pin,
  input logic              qmap_en,
  input logic [2*SW-1:0]   fold_addr
);

  a_r3_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> err_vld);

  a_r3_vld_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> !err_vld);

  a_r3_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(err_loop));

  a_r9_pin_match: assert property (@(posedge clk) disable iff (!rst_n)
    err_pin == err_loop);

  a_r5_table_unreadable: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_addr[CFG_AW-1] |-> (cfg_rdata == '0));

  a_r6_rdata_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[WORD_W-1:1] == '0);

  a_r6_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && (cfg_addr == '0)) |=> (qmap_en == $past(cfg_wdata[0])));

  a_r7_sign_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    qmap_en |-> (!fold_addr[2*SW-1] && !fold_addr[SW-1]));

endmodule

bind qpe_phase_lut qpe_phase_lut_chk #(
  .SW     (SW),
  .WORD_W (WORD_W),
  .CFG_AW (CFG_AW)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cfg_wr    (cfg_wr),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .smp_vld   (smp_vld),
  .err_vld   (err_vld),
  .err_loop  (err_loop),
  .err_pin   (err_pin),
  .qmap_en   (qmap_en),
  .fold_addr (fold_addr)
);

// File: tb/test_qpe_phase_lut.sv
module test_qpe_phase_lut;

  logic        clk;
  logic        rst_n;
  logic        cfg_wr;
  logic [8:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic [15:0] cfg_rdata;
  logic        smp_vld;
  logic [5:0]  smp_i;
  logic [5:0]  smp_q;
  logic        err_vld;
  logic        err_loop;
  logic        err_pin;

  int n_chk;
  int n_bad;
  bit done;

  logic [15:0] model [256];
  bit          model_qm;

  qpe_phase_lut i_qpe_phase_lut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .smp_vld   (smp_vld),
    .smp_i     (smp_i),
    .smp_q     (smp_q),
    .err_vld   (err_vld),
    .err_loop  (err_loop),
    .err_pin   (err_pin)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [4:0] mag5(input logic [5:0] v);
    int s;
    s = $signed(v);
    if (s < 0) s = -s;
    if (s > 31) s = 31;
    return s[4:0];
  endfunction

  function automatic bit exp_err(input logic [5:0] i, input logic [5:0] q, input bit qm);
    logic [11:0] a;
    bit          b;
    if (qm) a = {1'b0, mag5(i), 1'b0, mag5(q)};
    else    a = {i, q};
    b = model[a[11:4]][a[3:0]];
    return qm ? (b ^ (i[5] ^ q[5])) : b;
  endfunction

  task automatic cfg_write(input int a, input logic [15:0] d);
    @(negedge clk);
    cfg_wr    = 1'b1;
    cfg_addr  = 9'(a);
    cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (a >= 256 && a <= 511) model[a - 256] = d;
    if (a == 0) model_qm = d[0];
  endtask

  task automatic cfg_read_check(input int a, input logic [15:0] exp, input string req);
    cfg_addr = 9'(a);
    #1;
    check(cfg_rdata == exp, req, int'(cfg_rdata), int'(exp));
  endtask

  // drive at a falling edge, check one rising edge later at the next falling edge
  task automatic apply(input logic [5:0] i, input logic [5:0] q, input bit hold, input string req);
    bit e;
    bit prev;
    e = exp_err(i, q, model_qm);
    @(negedge clk);
    smp_vld = 1'b1;
    smp_i   = i;
    smp_q   = q;
    @(negedge clk);
    smp_vld = 1'b0;
    smp_i   = ~i;
    smp_q   = ~q;
    check(err_vld == 1'b1, "R3 valid", int'(err_vld), 1);
    check(err_loop == e, req, int'(err_loop), int'(e));
    check(err_pin == err_loop, "R9 pin", int'(err_pin), int'(err_loop));
    if (hold) begin
      prev = err_loop;
      @(negedge clk);
      check(err_vld == 1'b0, "R3 idle", int'(err_vld), 0);
      check(err_loop == prev, "R3 hold", int'(err_loop), int'(prev));
    end
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    n_chk = 0; n_bad = 0; done = 0;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    smp_vld = 1'b0; smp_i = '0; smp_q = '0;
    model_qm = 1'b0;
    for (int w = 0; w < 256; w++) model[w] = '0;

    repeat (3) @(negedge clk);
    check(err_vld == 1'b0, "R1 vld in reset", int'(err_vld), 0);
    check(err_loop == 1'b0, "R1 loop in reset", int'(err_loop), 0);
    check(err_pin == 1'b0, "R1 pin in reset", int'(err_pin), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(err_vld == 1'b0 && err_loop == 1'b0, "R1 after release", int'(err_loop), 0);
    cfg_read_check(0, 16'h0000, "R1 mode off");

    // fill the table
    for (int w = 0; w < 256; w++) cfg_write(256 + w, 16'($urandom));

    // R5: table never reads back
    cfg_read_check(256, 16'h0000, "R5 addr 256");
    cfg_read_check(300, 16'h0000, "R5 addr 300");
    cfg_read_check(511, 16'h0000, "R5 addr 511");

    // R2 corners in normal mode
    apply(6'd0, 6'd0, 1'b1, "R2 addr 0");
    apply(6'h3F, 6'h3F, 1'b1, "R2 addr 4095");
    apply(6'h20, 6'h1F, 1'b0, "R2 addr 0x81F");
    apply(6'h15, 6'h2A, 1'b0, "R2 addr 0x56A");

    // R4: write a word and hit it at once, both polarities
    cfg_write(256 + 8'h5A, 16'hFFFF);
    apply(6'h16, 6'h27, 1'b0, "R4 new word ones");
    cfg_write(256 + 8'h5A, 16'h0000);
    apply(6'h16, 6'h27, 1'b0, "R4 new word zeros");

    // R6: writes below the table are ignored
    cfg_write(200, 16'hFFFF);
    apply(6'h32, 6'h08, 1'b0, "R6 table untouched");
    cfg_write(5, 16'h0001);
    cfg_read_check(0, 16'h0000, "R6 mode untouched");

    // R6: mode readback
    cfg_write(0, 16'hFFFF);
    cfg_read_check(0, 16'h0001, "R6 mode on");

    // R7 / R8 folding corners
    apply(6'h20, 6'h20, 1'b1, "R7 -32,-32");
    apply(6'h20, 6'h05, 1'b0, "R8 -32,5");
    apply(6'h05, 6'h20, 1'b0, "R8 5,-32");
    apply(6'h00, 6'h3F, 1'b0, "R8 0,-1");
    apply(6'h3F, 6'h00, 1'b0, "R8 -1,0");
    apply(6'h1F, 6'h21, 1'b0, "R8 31,-31");
    apply(6'h3F, 6'h3F, 1'b0, "R7 -1,-1");
    apply(6'h0A, 6'h13, 1'b1, "R7 10,19");

    cfg_write(0, 16'hFFFE);
    cfg_read_check(0, 16'h0000, "R6 mode off again");

    // random traffic
    for (int n = 0; n < 1500; n++) begin
      int r;
      r = int'($urandom_range(0, 19));
      if (r == 0) cfg_write(0, 16'($urandom));
      else if (r == 1) cfg_write(256 + int'($urandom_range(0, 255)), 16'($urandom));
      else apply(6'($urandom), 6'($urandom), ($urandom_range(0, 3) == 0),
                 model_qm ? "R8 random fold" : "R2 random plain");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule